// File: doc/BRIEF.md
# Lane-Partitioned Vector Permute Unit

This block rearranges the elements of two 256-bit operands. It treats each operand as two independent 128-bit lanes, and every operation stays inside its lane. Three operations are supported. Interleave-low and interleave-high merge alternating elements from the two operands. Both work at 8, 16, 32 or 64-bit element sizes. The immediate-controlled permute reorders the 32-bit elements of the first operand. One 8-bit selector pattern is shared by both lanes, and each lane indexes only its own elements. A narrow-mode input restricts the unit to a single 128-bit lane and clears the upper half of the result.

Operations arrive on a valid/ready stream and leave through one registered result stage. The rules for back-pressure are as follows. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output stage is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the result stays frozen and no new operation is taken. An illegal request produces a zero result with `out_err` set, and that result travels with the data.

Top module: `vlane_perm`

## Requirements
- R1: In wide mode (`in_narrow`=0), every element of result bits [255:128] is drawn only from operand bits [255:128], and every element of result bits [127:0] is drawn only from operand bits [127:0].
- R2: Interleave-low (`in_op`=0) in a lane of N elements produces result element 2i = operand A element i and result element 2i+1 = operand B element i, for i = 0 to N/2-1. Element 0 is the least significant element of the lane.
- R3: Interleave-high (`in_op`=1) produces result element 2i = A element N/2+i and result element 2i+1 = B element N/2+i within each lane.
- R4: The permute (`in_op`=2, 32-bit elements) sets result element i of each lane to A element `in_imm[2i+1:2i]` of that same lane. The same selector values apply in both lanes.
- R5: `in_size` encodes the element width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. A lane therefore holds 16, 8, 4 or 2 elements, and the interleaves follow that count.
- R6: With `in_narrow`=1, only bits [127:0] are computed, as one lane, and result bits [255:128] are zero.
- R7: `in_op`=3, or `in_op`=2 with `in_size`≠2, is illegal. It gives an all-zero result with `out_err`=1. Legal operations give `out_err`=0.
- R8: `in_ready` = !`out_valid` || `out_ready`. An accepted operation appears on `out_data`/`out_err` with `out_valid`=1 on the following cycle. This holds even when the previous result drains on the same edge.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data`, `out_err` and `out_valid` hold, and `in_ready` is 0.
- R10: After reset, `out_valid`=0, `out_data`=0, `out_err`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request valid |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 2 | 0 interleave-low, 1 interleave-high, 2 permute, 3 reserved |
| in_size | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64 bits) |
| in_narrow | input | 1 | 1 selects single 128-bit lane operation |
| in_imm | input | 8 | Permute selector, two bits per 32-bit element |
| in_a | input | 256 | First operand |
| in_b | input | 256 | Second operand |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 256 | Result vector |
| out_err | output | 1 | Result came from an illegal request |

## Verification
Two functions can fall on the same edge: draining a held result and accepting the next operation. The bench first stalls the consumer while a second request waits. It confirms that the stored result stays frozen and that `in_ready` stays low. It then raises `out_ready` while the request is still pending, and expects the new result to follow the old one with `out_valid` never dropping. All other results are judged against an arithmetic model that works element by element, over every opcode, size and mode, and over all 256 permute selectors.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  localparam int LANE_W    = 128;
  localparam int NUM_SIZES = 4;
  localparam logic [1:0] OP_ILO  = 2'd0;
  localparam logic [1:0] OP_IHI  = 2'd1;
  localparam logic [1:0] OP_PERM = 2'd2;
  localparam logic [1:0] OP_RSVD = 2'd3;
  localparam logic [1:0] SZ_32   = 2'd2;

  function automatic logic op_illegal(input logic [1:0] op, input logic [1:0] sz);
    return (op == OP_RSVD) || ((op == OP_PERM) && (sz != SZ_32));
  endfunction
endpackage

// File: rtl/vlp_lane_interleave.sv
module vlp_lane_interleave #(
  parameter int LANE_W = 128,
  parameter int ELEM_W = 8
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic              upper_half,
  output logic [LANE_W-1:0] y
);
  localparam int NELEM = LANE_W / ELEM_W;
  localparam int HALF  = NELEM / 2;

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    assign y[(2*i)*ELEM_W +: ELEM_W]   = upper_half ? a[(HALF+i)*ELEM_W +: ELEM_W]
                                                    : a[i*ELEM_W +: ELEM_W];
    assign y[(2*i+1)*ELEM_W +: ELEM_W] = upper_half ? b[(HALF+i)*ELEM_W +: ELEM_W]
                                                    : b[i*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/vlp_lane_permute.sv
module vlp_lane_permute #(
  parameter int LANE_W = 128,
  parameter int ELEM_W = 32,
  localparam int NELEM = LANE_W / ELEM_W,
  localparam int SEL_W = $clog2(NELEM),
  localparam int IMM_W = NELEM * SEL_W
) (
  input  logic [LANE_W-1:0] a,
  input  logic [IMM_W-1:0]  sel,
  output logic [LANE_W-1:0] y
);
  logic [ELEM_W-1:0] elems [NELEM];

  for (genvar k = 0; k < NELEM; k++) begin : g_split
    assign elems[k] = a[k*ELEM_W +: ELEM_W];
  end

  for (genvar i = 0; i < NELEM; i++) begin : g_pick
    assign y[i*ELEM_W +: ELEM_W] = elems[sel[i*SEL_W +: SEL_W]];
  end
endmodule

// File: rtl/vlane_perm.sv
module vlane_perm
  import vlp_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int IMM_W     = 8,
  localparam int DATA_W   = LANE_W * NUM_LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [1:0]        in_size,
  input  logic              in_narrow,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err
);
  logic              accept;
  logic              illegal;
  logic [DATA_W-1:0] nxt_data;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign illegal  = op_illegal(in_op, in_size);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    localparam bit UPPER = (l != 0);
    logic [LANE_W-1:0] la, lb, pm_res, lane_res;
    logic [LANE_W-1:0] il_res [NUM_SIZES];

    assign la = in_a[l*LANE_W +: LANE_W];
    assign lb = in_b[l*LANE_W +: LANE_W];

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      vlp_lane_interleave #(.LANE_W(LANE_W), .ELEM_W(8 << s)) u_il (
        .a(la), .b(lb), .upper_half(in_op == OP_IHI), .y(il_res[s])
      );
    end

    vlp_lane_permute #(.LANE_W(LANE_W), .ELEM_W(32)) u_pm (
      .a(la), .sel(in_imm), .y(pm_res)
    );

    always_comb begin
      case (in_op)
        OP_ILO, OP_IHI: lane_res = il_res[in_size];
        OP_PERM:        lane_res = pm_res;
        default:        lane_res = '0;
      endcase
      if (illegal || (in_narrow && UPPER)) lane_res = '0;
    end

    assign nxt_data[l*LANE_W +: LANE_W] = lane_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= nxt_data;
      out_err   <= illegal;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

  assert_narrow_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_narrow) |=> (out_data[DATA_W-1:LANE_W] == '0));

  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_data == '0));

  assert_illegal_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == OP_RSVD) |=> out_err);
endmodule

// File: tb/vlane_perm_tb.sv
module vlane_perm_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_op = '0;
  logic [1:0]   in_size = '0;
  logic         in_narrow = 1'b0;
  logic [7:0]   in_imm = '0;
  logic [255:0] in_a = '0;
  logic [255:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] out_data;
  logic         out_err;

  int errors = 0;
  int total  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  vlane_perm u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_narrow(in_narrow), .in_imm(in_imm),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_err(out_err)
  );

  function automatic bit model_err(input int op, input int sz);
    return (op == 3) || (op == 2 && sz != 2);
  endfunction

  function automatic logic [255:0] model(input int op, input int sz, input bit nar,
                                         input logic [7:0] imm,
                                         input logic [255:0] a, input logic [255:0] b);
    logic [255:0] r;
    int ew, n, lanes, idx;
    r = '0;
    if (model_err(op, sz)) return r;
    ew = 8 << sz;
    n = 128 / ew;
    lanes = nar ? 1 : 2;
    for (int l = 0; l < lanes; l++) begin
      for (int k = 0; k < n; k++) begin
        if (op == 2) idx = l*n + int'((imm >> (2*k)) & 8'd3);
        else         idx = l*n + ((op == 1) ? n/2 : 0) + k/2;
        for (int t = 0; t < ew; t++)
          r[(l*n+k)*ew + t] = (op != 2 && (k % 2) == 1) ? b[idx*ew + t] : a[idx*ew + t];
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input int op, input int sz, input bit nar, input logic [7:0] imm,
                        input logic [255:0] a, input logic [255:0] b, input string req);
    logic [255:0] exp;
    bit eerr;
    @(negedge clk);
    in_valid = 1'b1; in_op = op[1:0]; in_size = sz[1:0]; in_narrow = nar;
    in_imm = imm; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    exp  = model(op, sz, nar, imm, a, b);
    eerr = model_err(op, sz);
    check(out_valid && out_data == exp && out_err == eerr, req, out_data, exp);
  endtask

  function automatic logic [255:0] pattern(input int p, input bit second);
    logic [255:0] v;
    for (int w = 0; w < 32; w++) v[w*8 +: 8] = 8'(w + (second ? 8'h80 : 8'h00));
    if (p != 0) for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  initial begin
    logic [255:0] a, b, e1, e2;
    string req;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!out_valid && out_data == '0 && !out_err && in_ready, "R10 reset", out_data, '0);

    // R1 R2 R3 R5 R6 R7 sweep over ops, sizes, modes, data
    for (int p = 0; p < 3; p++) begin
      a = pattern(p, 1'b0);
      b = pattern(p, 1'b1);
      for (int op = 0; op < 4; op++)
        for (int sz = 0; sz < 4; sz++)
          for (int nar = 0; nar < 2; nar++) begin
            if (model_err(op, sz)) req = "R7 illegal";
            else if (op == 0) req = nar ? "R2 R5 R6 low" : "R1 R2 R5 low";
            else if (op == 1) req = nar ? "R3 R5 R6 high" : "R1 R3 R5 high";
            else req = nar ? "R4 R6 perm" : "R1 R4 perm";
            run_op(op, sz, nar[0], 8'h1B, a, b, req);
          end
    end

    // R4 all selectors, both modes
    a = pattern(1, 1'b0);
    b = pattern(1, 1'b1);
    for (int imm = 0; imm < 256; imm++)
      for (int nar = 0; nar < 2; nar++)
        run_op(2, 2, nar[0], imm[7:0], a, b, "R4 permute selector");

    // R9 back-pressure, then R8 drain and accept on the same edge
    a = pattern(2, 1'b0);
    b = pattern(2, 1'b1);
    e1 = model(0, 1, 1'b0, 8'h00, a, b);
    e2 = model(2, 2, 1'b0, 8'hE4, b, a);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'd0; in_size = 2'd1; in_narrow = 1'b0; in_a = a; in_b = b;
    @(negedge clk);
    check(out_valid && out_data == e1, "R8 first result", out_data, e1);
    in_op = 2'd2; in_size = 2'd2; in_imm = 8'hE4; in_a = b; in_b = a;
    #1;
    check(!in_ready, "R9 ready low while stalled", {255'd0, in_ready}, '0);
    repeat (2) @(negedge clk);
    check(out_valid && out_data == e1 && !out_err, "R9 hold", out_data, e1);
    out_ready = 1'b1;
    #1;
    check(in_ready, "R8 ready with drain", {255'd0, in_ready}, 256'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == e2, "R8 drain and accept", out_data, e2);
    @(negedge clk);
    check(!out_valid, "R8 drained", {255'd0, out_valid}, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule